// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block produces an audio main clock and an audio bit clock from a faster system clock. A phase accumulator adds a numerator X on every enabled system cycle. Whenever the sum reaches the denominator Y, it subtracts Y and emits one tick. Each tick flips the main clock, so the main clock runs at half the system rate scaled by X/Y, and its high and low phases differ by at most one system cycle. The same ticks drive a second divider that flips the bit clock every N+1 ticks. As a result, the bit clock period is exactly N+1 main clock periods.

Every output edge lands on a system clock edge. Ratios where Y is not a multiple of X therefore show period jitter of one system cycle per tick, while ratios where X divides Y are jitter free. Settings are sampled only while the enable is low and are frozen while it is high. A bad ratio (X or Y zero, or X above Y) raises an error flag and keeps both clocks low. Each clock also comes with a one-cycle strobe that marks its rising edge, for logic that runs on the system clock.

Top module: `acg_top`

## Requirements
- R1: While reset is asserted, mclk_o, bclk_o, mclk_stb_o, bclk_stb_o and cfg_err_o are all 0.
- R2: After a system clock edge that samples en_i low, both clocks and both strobes are 0 and stay 0 until en_i is high again.
- R3: Counting from the first edge that samples en_i high, exactly X*M rising edges of mclk_o occur within 2*Y*M system cycles, for any whole M.
- R4: When Y is a multiple of X, every mclk_o period is exactly 2*Y/X system cycles.
- R5: Every mclk_o period lies between 2*floor(Y/X) and 2*ceil(Y/X) system cycles, and every high phase lies between floor(Y/X) and ceil(Y/X) cycles.
- R6: Consecutive rising edges of bclk_o are separated by exactly N+1 rising edges of mclk_o.
- R7: With N = 0, bclk_o equals mclk_o in every cycle.
- R8: With X = Y, mclk_o rises on the first enabled edge and toggles on every enabled cycle.
- R9: If X = 0, Y = 0 or X > Y, cfg_err_o is 1 one edge after the setting is applied with en_i low, and both clocks stay 0 while enabled. A valid setting gives cfg_err_o = 0.
- R10: Changes to X, Y or N while en_i is high have no effect until en_i has been low for at least one edge.
- R11: mclk_stb_o (bclk_stb_o) is 1 in exactly the cycles where mclk_o (bclk_o) has just gone from 0 to 1.
- R12: While enabled, bclk_o changes only in cycles where mclk_o also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable. Settings are captured while it is low |
| num_x_i | input | 8 | Ratio numerator X |
| den_y_i | input | 8 | Ratio denominator Y |
| div_n_i | input | 8 | Bit clock divide setting N (divide by N+1) |
| mclk_o | output | 1 | Main clock level |
| bclk_o | output | 1 | Bit clock level |
| mclk_stb_o | output | 1 | One-cycle strobe on the main clock rising edge |
| bclk_stb_o | output | 1 | One-cycle strobe on the bit clock rising edge |
| cfg_err_o | output | 1 | Captured setting is invalid |

## Verification
The hardest case to reach is a configuration change made while the block is running. The new values must not leak into the accumulator, so the stimulus rewrites X, Y and N halfway through an enabled window. It then checks that the main clock edge count over that window still matches the old ratio, and that only a disable and re-enable brings in the new ratio. The rounding boundaries for jitter also need stimulus chosen on purpose. Near-unity ratios such as 200/201 and sparse ones such as 7/255 push the tick spacing to both its floor and its ceiling, and the bench measures every period against those limits.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the fractional audio clock generator.
package acg_pkg;
    // Default width of the X, Y and N settings.
    localparam int unsigned ACG_CFG_W = 8;

    // Output stage state: clock level plus rising-edge strobe.
    typedef struct packed {
        logic level;
        logic rise;
    } acg_clk_t;
endpackage

// File: rtl/acg_cfg_shadow.sv
`timescale 1ns/1ps
// Holds the working copy of X, Y and N.
// Loads from the inputs on every edge while en_i is low and keeps its value while en_i is high.
// Assumes the inputs are stable for at least one edge before enabling.
module acg_cfg_shadow #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] n_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] n_o,
    output logic         valid_o
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    // Capture the settings while idle; reset to a valid 1/1 ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= ONE;
            y_o <= ONE;
            n_o <= ZERO;
        end else if (!en_i) begin
            x_o <= x_i;
            y_o <= y_i;
            n_o <= n_i;
        end
    end

    // A ratio is usable when both terms are nonzero and X does not exceed Y.
    always_comb begin
        valid_o = (x_o != ZERO) && (y_o != ZERO) && (x_o <= y_o);
    end
endmodule

// File: rtl/acg_frac_accum.sv
`timescale 1ns/1ps
// Phase accumulator that issues ticks at an average rate of X/Y per system cycle.
// Assumes 0 < X <= Y when run_i is high, so the accumulator always stays below Y.
// The tick is combinational and valid in the cycle the sum reaches Y.
module acg_frac_accum #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic         tick_o
);
    localparam int unsigned SW = W + 1;

    logic [W-1:0]  acc_q;
    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;
    logic          hit;

    // Form the next phase and test it against the denominator.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, x_i};
        hit     = sum >= {1'b0, y_i};
        wrapped = sum - {1'b0, y_i};
        tick_o  = run_i && hit;
    end

    // Advance the phase; clear it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            acc_q <= '0;
        end else if (hit) begin
            acc_q <= wrapped[W-1:0];
        end else begin
            acc_q <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/acg_clk_toggle.sv
`timescale 1ns/1ps
// Divide-by-two stage: flips the main clock on each tick.
// Produces a strobe in the cycle the level rises.
// Assumes ticks arrive only while run_i is high.
module acg_clk_toggle (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    output acg_pkg::acg_clk_t clk_o
);
    // Flip the level on a tick; flag a 0-to-1 change; clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            clk_o <= '0;
        end else begin
            clk_o.rise <= tick_i && !clk_o.level;
            if (tick_i) begin
                clk_o.level <= !clk_o.level;
            end
        end
    end
endmodule

// File: rtl/acg_bclk_div.sv
`timescale 1ns/1ps
// Bit clock divider: counts main clock toggles and flips the bit clock every N+1 of them.
// The bit clock period is therefore N+1 main clock periods.
// Assumes n_i is stable while run_i is high.
module acg_bclk_div #(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [W-1:0]      n_i,
    output acg_pkg::acg_clk_t clk_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         wrap;

    // The count has reached the end of a half period.
    always_comb begin
        wrap = tick_i && (cnt_q == n_i);
    end

    // Step the toggle count on each tick, restarting it at N.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Flip the bit clock at each wrap and mark its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            clk_o <= '0;
        end else begin
            clk_o.rise <= wrap && !clk_o.level;
            if (wrap) begin
                clk_o.level <= !clk_o.level;
            end
        end
    end
endmodule

// File: rtl/acg_top.sv
`timescale 1ns/1ps
// Fractional audio clock generator top.
// Main clock = f_clk/2 * X/Y; bit clock = main clock / (N+1).
// Settings are captured while en_i is low. An invalid ratio holds both clocks low and raises cfg_err_o.
module acg_top #(
    parameter int unsigned CFG_W = acg_pkg::ACG_CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CFG_W-1:0] num_x_i,
    input  logic [CFG_W-1:0] den_y_i,
    input  logic [CFG_W-1:0] div_n_i,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             mclk_stb_o,
    output logic             bclk_stb_o,
    output logic             cfg_err_o
);
    logic [CFG_W-1:0]  x_s;
    logic [CFG_W-1:0]  y_s;
    logic [CFG_W-1:0]  n_s;
    logic              cfg_ok;
    logic              run;
    logic              tick;
    acg_pkg::acg_clk_t m_st;
    acg_pkg::acg_clk_t b_st;

    acg_cfg_shadow #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .x_i     (num_x_i),
        .y_i     (den_y_i),
        .n_i     (div_n_i),
        .x_o     (x_s),
        .y_o     (y_s),
        .n_o     (n_s),
        .valid_o (cfg_ok)
    );

    // Run only when enabled with a usable ratio.
    always_comb begin
        run = en_i && cfg_ok;
    end

    acg_frac_accum #(.W(CFG_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .x_i    (x_s),
        .y_i    (y_s),
        .tick_o (tick)
    );

    acg_clk_toggle u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick),
        .clk_o  (m_st)
    );

    acg_bclk_div #(.W(CFG_W)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick),
        .n_i    (n_s),
        .clk_o  (b_st)
    );

    // Drive the outputs from the stage registers.
    always_comb begin
        mclk_o     = m_st.level;
        mclk_stb_o = m_st.rise;
        bclk_o     = b_st.level;
        bclk_stb_o = b_st.rise;
        cfg_err_o  = !cfg_ok;
    end
endmodule

// File: rtl/acg_checker.sv
`timescale 1ns/1ps
// Port-level protocol checks for acg_top, attached with bind.
module acg_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic mclk_o,
    input logic bclk_o,
    input logic mclk_stb_o,
    input logic bclk_stb_o,
    input logic cfg_err_o
);
    // R2: an edge that sees the enable low leaves everything quiet.
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!mclk_o && !bclk_o && !mclk_stb_o && !bclk_stb_o));

    // R9: a bad ratio never lets a clock out.
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!mclk_o && !bclk_o));

    // R11: main strobe only on a fresh rise, and every rise is strobed.
    a_r11_mstb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_stb_o |-> (mclk_o && !$past(mclk_o)));
    a_r11_mrise_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_o) |-> mclk_stb_o);

    // R11: same pairing for the bit clock.
    a_r11_bstb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb_o |-> (bclk_o && !$past(bclk_o)));
    a_r11_brise_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) |-> bclk_stb_o);

    // R12: while running, the bit clock moves only together with the main clock.
    a_r12_bclk_with_mclk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !$stable(bclk_o)) |-> !$stable(mclk_o));
endmodule

bind acg_top acg_checker u_acg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .mclk_o     (mclk_o),
    .bclk_o     (bclk_o),
    .mclk_stb_o (mclk_stb_o),
    .bclk_stb_o (bclk_stb_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/tb_acg_top.sv
`timescale 1ns/1ps
// Self-checking bench for acg_top: table walk of ratios, then directed cases.
module tb_acg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] num_x_i = 8'd1;
    logic [7:0] den_y_i = 8'd1;
    logic [7:0] div_n_i = 8'd0;
    logic       mclk_o, bclk_o, mclk_stb_o, bclk_stb_o, cfg_err_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    acg_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .num_x_i    (num_x_i),
        .den_y_i    (den_y_i),
        .div_n_i    (div_n_i),
        .mclk_o     (mclk_o),
        .bclk_o     (bclk_o),
        .mclk_stb_o (mclk_stb_o),
        .bclk_stb_o (bclk_stb_o),
        .cfg_err_o  (cfg_err_o)
    );

    // Stimulus table: {X, Y, N}.
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {8'd1,   8'd1,   8'd0},
        {8'd2,   8'd4,   8'd1},
        {8'd3,   8'd9,   8'd2},
        {8'd1,   8'd4,   8'd3},
        {8'd3,   8'd7,   8'd0},
        {8'd5,   8'd8,   8'd2},
        {8'd7,   8'd255, 8'd1},
        {8'd200, 8'd201, 8'd4},
        {8'd255, 8'd255, 8'd255}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Load a setting with the enable low, allowing two edges for capture.
    task automatic load_cfg(input int x, input int y, input int n);
        @(negedge clk);
        en_i    = 1'b0;
        num_x_i = 8'(x);
        den_y_i = 8'(y);
        div_n_i = 8'(n);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Enable and observe 2*Y*M cycles, then check R3..R8, R11, R12.
    task automatic run_window(input int x, input int y, input int n, input int m);
        int w, rises, last_rise, pmin, pmax, hmin, hmax;
        int mcnt, bad_b, bad_stb, bad_sync, bad_eq, brises, first_rise;
        bit prev_m, prev_b, bseen;
        int fl, cl;
        w = 2 * y * m;
        rises = 0; last_rise = 0; pmin = 1 << 30; pmax = 0; hmin = 1 << 30; hmax = 0;
        mcnt = 0; bad_b = 0; bad_stb = 0; bad_sync = 0; bad_eq = 0; brises = 0;
        first_rise = 0; prev_m = 1'b0; prev_b = 1'b0; bseen = 1'b0;
        fl = y / x;
        cl = (y + x - 1) / x;
        en_i = 1'b1;
        for (int c = 1; c <= w; c++) begin
            bit mr, mf, br;
            @(negedge clk);
            mr = mclk_o && !prev_m;
            mf = !mclk_o && prev_m;
            br = bclk_o && !prev_b;
            if (mclk_stb_o != mr || bclk_stb_o != br) bad_stb++;
            if ((bclk_o != prev_b) && (mclk_o == prev_m)) bad_sync++;
            if (n == 0 && bclk_o != mclk_o) bad_eq++;
            if (mr) begin
                rises++;
                mcnt++;
                if (first_rise == 0) first_rise = c;
                if (last_rise > 0) begin
                    if (c - last_rise < pmin) pmin = c - last_rise;
                    if (c - last_rise > pmax) pmax = c - last_rise;
                end
                last_rise = c;
            end
            if (mf && last_rise > 0) begin
                if (c - last_rise < hmin) hmin = c - last_rise;
                if (c - last_rise > hmax) hmax = c - last_rise;
            end
            if (br) begin
                brises++;
                if (bseen && mcnt != n + 1) bad_b++;
                bseen = 1'b1;
                mcnt = 0;
            end
            prev_m = mclk_o;
            prev_b = bclk_o;
        end
        // R3: exact rising-edge count over the window.
        check(rises == x * m, "R3", "mclk rises in window", rises, x * m);
        // R5: period and high-phase bounds.
        check(pmin >= 2 * fl && pmax <= 2 * cl, "R5", "mclk max period", pmax, 2 * cl);
        check(hmin >= fl && hmax <= cl, "R5", "mclk min high phase", hmin, fl);
        // R4: jitter-free ratios.
        if (y % x == 0)
            check(pmin == 2 * y / x && pmax == 2 * y / x, "R4", "mclk period", pmin, 2 * y / x);
        // R6: bit clock spacing in main clock edges.
        check(bad_b == 0 && brises >= 2, "R6", "bad bclk intervals", bad_b, 0);
        // R7: identical clocks when N is zero.
        if (n == 0) check(bad_eq == 0, "R7", "bclk/mclk mismatches", bad_eq, 0);
        // R8: unity ratio rises on the first enabled edge.
        if (x == y) check(first_rise == 1 && pmax == 2, "R8", "first rise cycle", first_rise, 1);
        // R11: strobes match the rising edges.
        check(bad_stb == 0, "R11", "strobe mismatches", bad_stb, 0);
        // R12: bit clock moves only with the main clock.
        check(bad_sync == 0, "R12", "lone bclk changes", bad_sync, 0);
        @(negedge clk);
        en_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state, even with the enable high.
        en_i = 1'b1;
        repeat (5) @(negedge clk);
        check({mclk_o, bclk_o, mclk_stb_o, bclk_stb_o, cfg_err_o} == 5'b0, "R1",
              "outputs in reset", int'({mclk_o, bclk_o, mclk_stb_o, bclk_stb_o, cfg_err_o}), 0);
        en_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            int x, y, n, m;
            x = int'(VEC[i][23:16]);
            y = int'(VEC[i][15:8]);
            n = int'(VEC[i][7:0]);
            m = (3 * (n + 1)) / x + 2;
            load_cfg(x, y, n);
            check(cfg_err_o == 1'b0, "R9", "cfg_err on valid ratio", int'(cfg_err_o), 0);
            run_window(x, y, n, m);
        end

        // R2: disable mid-run silences outputs.
        begin
            int loud;
            loud = 0;
            load_cfg(3, 7, 0);
            en_i = 1'b1;
            repeat (30) @(negedge clk);
            en_i = 1'b0;
            repeat (20) begin
                @(negedge clk);
                if (mclk_o || bclk_o || mclk_stb_o || bclk_stb_o) loud++;
            end
            check(loud == 0, "R2", "active cycles while disabled", loud, 0);
        end

        // R9: invalid ratios.
        begin
            int bad_x [3] = '{0, 5, 6};
            int bad_y [3] = '{5, 0, 5};
            for (int k = 0; k < 3; k++) begin
                int loud;
                loud = 0;
                load_cfg(bad_x[k], bad_y[k], 0);
                check(cfg_err_o == 1'b1, "R9", "cfg_err on bad ratio", int'(cfg_err_o), 1);
                en_i = 1'b1;
                repeat (40) begin
                    @(negedge clk);
                    if (mclk_o || bclk_o) loud++;
                end
                check(loud == 0, "R9", "clock activity on bad ratio", loud, 0);
                en_i = 1'b0;
            end
        end

        // R10: settings rewritten while running are ignored until re-enable.
        begin
            int rises;
            bit prev_m;
            rises = 0;
            prev_m = 1'b0;
            load_cfg(1, 4, 0);
            en_i = 1'b1;
            for (int c = 1; c <= 80; c++) begin
                @(negedge clk);
                if (mclk_o && !prev_m) rises++;
                prev_m = mclk_o;
                if (c == 40) begin
                    num_x_i = 8'd1;
                    den_y_i = 8'd1;
                    div_n_i = 8'd3;
                end
            end
            check(rises == 10, "R10", "rises with rewrite while enabled", rises, 10);
            @(negedge clk);
            en_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
            run_window(1, 1, 3, 10);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule